// File: doc/BRIEF.md
# AXI Request Trap Mailbox

This block sits on the bus path of one on-chip AXI master whose memory requests have to be serviced by software running on a host. The master talks to a single-beat AXI slave port. Each read or write it issues is taken in and held: the block never answers on its own. The direction, address, ID, size code, write data and byte strobes are latched into a small register file. A level interrupt tells the host that a request is waiting.

The host reads the captured fields through a second, AXI4-Lite register port. It then writes the response payload and the response code, and issues a completion command. Only then does the block return the B or R beat to the master, carrying the captured ID. The block holds only one request at a time. While a request is held or its response is still waiting for the master's ready, no new address or data is accepted. A system with several such masters uses one instance per master.

Top module: `bus_trap_mailbox`

## Requirements
- R1: In the idle state, a write is taken only when AW and W are both valid, and then in a single cycle with awready and wready both high. Its ID, address, size code, data and strobes are latched. Host register 0x00 then reads bit 0 = 1 (pending) and bit 1 = 1 (write).
- R2: In the idle state, a read is taken when arvalid is high and awvalid is low. Its ID, address and size code are latched. The data register (0x08) and the strobe register (0x10) then read 0, and 0x00 reads bit 0 = 1, bit 1 = 0.
- R3: irq rises on the clock edge after a request is accepted. It stays high until the edge on which the host's completion command is accepted, and is low from that edge on.
- R4: From the accepting edge until the response handshake on the request port, awready, wready and arready stay low, even if requests are presented.
- R5: No bvalid or rvalid is raised on the request port before the completion command, a host write of 0x1C with strobe bit 0 and data bit 0 both set.
- R6: After the completion command for a write, bvalid rises on the next edge. bid is the captured ID and bresp is the code the host wrote to 0x18 bits [1:0]. These are held until bready.
- R7: After the completion command for a read, rvalid rises on the next edge with rlast = 1. rid is the captured ID, rdata is the 0x14 register and rresp is the 0x18 code. These are held until rready.
- R8: If awvalid, wvalid and arvalid are all high while the block is idle, the write is taken first. The read is taken only after the write's B handshake.
- R9: A completion command written while nothing is pending produces no response beat, leaves irq low and leaves register 0x00 unchanged.
- R10: The host register map is 0x00 status, 0x04 address, 0x08 write data, 0x0C size code, 0x10 strobes, 0x14 response data, 0x18 response code and 0x1C command, with word index = address bits [4:2]. Writes to 0x14 honour the byte strobes. Writes to 0x00 through 0x10 are ignored. Host bresp and rresp are always OKAY (0).
- R11: After reset, irq, bvalid, rvalid and all request-port readies are low, and register 0x00 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqAwId | input | ID_W | Request write ID |
| reqAwAddr | input | ADDR_W | Request write address |
| reqAwSize | input | 3 | Request write size code |
| reqAwValid | input | 1 | Write address valid |
| reqAwReady | output | 1 | Write address ready |
| reqWData | input | DATA_W | Write data |
| reqWStrb | input | DATA_W/8 | Write byte strobes |
| reqWValid | input | 1 | Write data valid |
| reqWReady | output | 1 | Write data ready |
| reqBId | output | ID_W | Write response ID |
| reqBResp | output | 2 | Write response code |
| reqBValid | output | 1 | Write response valid |
| reqBReady | input | 1 | Write response ready |
| reqArId | input | ID_W | Read ID |
| reqArAddr | input | ADDR_W | Read address |
| reqArSize | input | 3 | Read size code |
| reqArValid | input | 1 | Read address valid |
| reqArReady | output | 1 | Read address ready |
| reqRId | output | ID_W | Read response ID |
| reqRData | output | DATA_W | Read data |
| reqRResp | output | 2 | Read response code |
| reqRLast | output | 1 | Last read beat (always 1) |
| reqRValid | output | 1 | Read data valid |
| reqRReady | input | 1 | Read data ready |
| hostAwAddr | input | HOST_AW | Host register write address |
| hostAwValid | input | 1 | Host write address valid |
| hostAwReady | output | 1 | Host write address ready |
| hostWData | input | DATA_W | Host write data |
| hostWStrb | input | DATA_W/8 | Host write strobes |
| hostWValid | input | 1 | Host write data valid |
| hostWReady | output | 1 | Host write data ready |
| hostBResp | output | 2 | Host write response (OKAY) |
| hostBValid | output | 1 | Host write response valid |
| hostBReady | input | 1 | Host write response ready |
| hostArAddr | input | HOST_AW | Host register read address |
| hostArValid | input | 1 | Host read address valid |
| hostArReady | output | 1 | Host read address ready |
| hostRData | output | DATA_W | Host read data |
| hostRResp | output | 2 | Host read response (OKAY) |
| hostRValid | output | 1 | Host read data valid |
| hostRReady | input | 1 | Host read data ready |
| irq | output | 1 | Level interrupt: a request is pending |

## Verification
The bound checker watches several rules on every cycle:

- No request-port ready while irq is high.
- No response beat while irq is high.
- irq only rises after an accepted address.
- AW and W are always taken together.
- A read is never taken while a write address is offered.
- Held B and R beats keep their payload stable.

The captured field values, the echoed ID, data and code, the ordering of simultaneous requests and the ignored stray completion command can only be shown by the bench's sweeps. The bench runs every response code in both directions and compares the register readbacks with values it derives arithmetically.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RESP = 2'd2
  } trapState_t;

  typedef struct packed {
    logic capWrite;
    logic capRead;
    logic loadRspData;
    logic loadRspCode;
    logic loadHostRd;
  } trapStrobe_t;

  localparam int unsigned REG_IDX_W = 3;
  typedef logic [REG_IDX_W-1:0] regIdx_t;

  localparam regIdx_t REG_STATUS = 3'd0;
  localparam regIdx_t REG_ADDR   = 3'd1;
  localparam regIdx_t REG_WDATA  = 3'd2;
  localparam regIdx_t REG_SIZE   = 3'd3;
  localparam regIdx_t REG_STRB   = 3'd4;
  localparam regIdx_t REG_RDATA  = 3'd5;
  localparam regIdx_t REG_RCODE  = 3'd6;
  localparam regIdx_t REG_CMD    = 3'd7;

  localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqAwValid,
  input  logic        reqWValid,
  input  logic        reqArValid,
  output logic        reqAwReady,
  output logic        reqWReady,
  output logic        reqArReady,
  output logic        reqBValid,
  input  logic        reqBReady,
  output logic        reqRValid,
  input  logic        reqRReady,
  input  logic        capIsWrite,
  input  logic        hostAwValid,
  input  logic        hostWValid,
  output logic        hostAwReady,
  output logic        hostWReady,
  output logic        hostBValid,
  input  logic        hostBReady,
  input  logic        hostArValid,
  output logic        hostArReady,
  output logic        hostRValid,
  input  logic        hostRReady,
  input  regIdx_t     hostWrIdx,
  input  logic        hostCmdBit,
  output logic        pending,
  output trapStrobe_t strobe
);

  trapState_t st, stNext;
  logic acceptWr, acceptRd, hostWrFire, hostRdFire, releaseReq, respDone;

  always_comb begin
    // write wins when both address channels are offered; AW and W go as a pair
    acceptWr   = (st == ST_IDLE) && reqAwValid && reqWValid;
    acceptRd   = (st == ST_IDLE) && !reqAwValid && reqArValid;
    hostWrFire = hostAwValid && hostWValid && !hostBValid;
    hostRdFire = hostArValid && !hostRValid;
    releaseReq = hostWrFire && (hostWrIdx == REG_CMD) && hostCmdBit && (st == ST_HOLD);
    respDone   = (st == ST_RESP) && (capIsWrite ? reqBReady : reqRReady);
  end

  always_comb begin
    stNext = st;
    unique case (st)
      ST_IDLE: if (acceptWr || acceptRd) stNext = ST_HOLD;
      ST_HOLD: if (releaseReq) stNext = ST_RESP;
      ST_RESP: if (respDone) stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hostBValid <= 1'b0;
    else if (hostWrFire) hostBValid <= 1'b1;
    else if (hostBReady) hostBValid <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hostRValid <= 1'b0;
    else if (hostRdFire) hostRValid <= 1'b1;
    else if (hostRReady) hostRValid <= 1'b0;
  end

  always_comb begin
    reqAwReady         = acceptWr;
    reqWReady          = acceptWr;
    reqArReady         = acceptRd;
    reqBValid          = (st == ST_RESP) && capIsWrite;
    reqRValid          = (st == ST_RESP) && !capIsWrite;
    hostAwReady        = hostWrFire;
    hostWReady         = hostWrFire;
    hostArReady        = !hostRValid;
    pending            = (st == ST_HOLD);
    strobe.capWrite    = acceptWr;
    strobe.capRead     = acceptRd;
    strobe.loadRspData = hostWrFire && (hostWrIdx == REG_RDATA);
    strobe.loadRspCode = hostWrFire && (hostWrIdx == REG_RCODE);
    strobe.loadHostRd  = hostRdFire;
  end

endmodule

// File: rtl/trap_dpath.sv
module trap_dpath
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  trapStrobe_t       strobe,
  input  logic              pending,
  input  logic [ID_W-1:0]   awId,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic [2:0]        awSize,
  input  logic [DATA_W-1:0] wData,
  input  logic [STRB_W-1:0] wStrb,
  input  logic [ID_W-1:0]   arId,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic [2:0]        arSize,
  input  regIdx_t           hostRdIdx,
  input  logic [DATA_W-1:0] hostWData,
  input  logic [STRB_W-1:0] hostWStrb,
  output logic              capIsWrite,
  output logic [ID_W-1:0]   rspId,
  output logic [DATA_W-1:0] rspData,
  output logic [1:0]        rspCode,
  output logic [DATA_W-1:0] hostRData
);

  logic [ADDR_W-1:0] capAddr;
  logic [2:0]        capSize;
  logic [DATA_W-1:0] capWData;
  logic [STRB_W-1:0] capWStrb;
  logic [7:0]        rspByte [STRB_W];
  logic [DATA_W-1:0] rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIsWrite <= 1'b0;
      rspId      <= '0;
      capAddr    <= '0;
      capSize    <= '0;
      capWData   <= '0;
      capWStrb   <= '0;
    end else if (strobe.capWrite) begin
      capIsWrite <= 1'b1;
      rspId      <= awId;
      capAddr    <= awAddr;
      capSize    <= awSize;
      capWData   <= wData;
      capWStrb   <= wStrb;
    end else if (strobe.capRead) begin
      capIsWrite <= 1'b0;
      rspId      <= arId;
      capAddr    <= arAddr;
      capSize    <= arSize;
      capWData   <= '0;
      capWStrb   <= '0;
    end
  end

  for (genvar b = 0; b < STRB_W; b++) begin : g_rspByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        rspByte[b] <= '0;
      else if (strobe.loadRspData && hostWStrb[b])
        rspByte[b] <= hostWData[b*8 +: 8];
    end
    assign rspData[b*8 +: 8] = rspByte[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 rspCode <= RESP_OKAY;
    else if (strobe.loadRspCode && hostWStrb[0]) rspCode <= hostWData[1:0];
  end

  always_comb begin
    rdMux = '0;
    unique case (hostRdIdx)
      REG_STATUS: begin
        rdMux[0] = pending;
        rdMux[1] = capIsWrite;
      end
      REG_ADDR:  rdMux = DATA_W'(capAddr);
      REG_WDATA: rdMux = capWData;
      REG_SIZE:  rdMux = DATA_W'(capSize);
      REG_STRB:  rdMux = DATA_W'(capWStrb);
      REG_RDATA: rdMux = rspData;
      REG_RCODE: rdMux = DATA_W'(rspCode);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hostRData <= '0;
    else if (strobe.loadHostRd) hostRData <= rdMux;
  end

endmodule

// File: rtl/bus_trap_mailbox.sv
module bus_trap_mailbox
  import trap_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ID_W    = 4,
  parameter int unsigned HOST_AW = 5,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   reqAwId,
  input  logic [ADDR_W-1:0] reqAwAddr,
  input  logic [2:0]        reqAwSize,
  input  logic              reqAwValid,
  output logic              reqAwReady,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [STRB_W-1:0] reqWStrb,
  input  logic              reqWValid,
  output logic              reqWReady,
  output logic [ID_W-1:0]   reqBId,
  output logic [1:0]        reqBResp,
  output logic              reqBValid,
  input  logic              reqBReady,
  input  logic [ID_W-1:0]   reqArId,
  input  logic [ADDR_W-1:0] reqArAddr,
  input  logic [2:0]        reqArSize,
  input  logic              reqArValid,
  output logic              reqArReady,
  output logic [ID_W-1:0]   reqRId,
  output logic [DATA_W-1:0] reqRData,
  output logic [1:0]        reqRResp,
  output logic              reqRLast,
  output logic              reqRValid,
  input  logic              reqRReady,
  input  logic [HOST_AW-1:0] hostAwAddr,
  input  logic              hostAwValid,
  output logic              hostAwReady,
  input  logic [DATA_W-1:0] hostWData,
  input  logic [STRB_W-1:0] hostWStrb,
  input  logic              hostWValid,
  output logic              hostWReady,
  output logic [1:0]        hostBResp,
  output logic              hostBValid,
  input  logic              hostBReady,
  input  logic [HOST_AW-1:0] hostArAddr,
  input  logic              hostArValid,
  output logic              hostArReady,
  output logic [DATA_W-1:0] hostRData,
  output logic [1:0]        hostRResp,
  output logic              hostRValid,
  input  logic              hostRReady,
  output logic              irq
);

  trapStrobe_t       strobe;
  logic              pending;
  logic              capIsWrite;
  logic [ID_W-1:0]   rspId;
  logic [DATA_W-1:0] rspData;
  logic [1:0]        rspCode;
  regIdx_t           hostWrIdx;
  regIdx_t           hostRdIdx;
  logic              unusedHostBits;

  assign hostWrIdx      = hostAwAddr[REG_IDX_W+1:2];
  assign hostRdIdx      = hostArAddr[REG_IDX_W+1:2];
  assign unusedHostBits = ^{hostAwAddr, hostArAddr};

  trap_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqAwValid  (reqAwValid),
    .reqWValid   (reqWValid),
    .reqArValid  (reqArValid),
    .reqAwReady  (reqAwReady),
    .reqWReady   (reqWReady),
    .reqArReady  (reqArReady),
    .reqBValid   (reqBValid),
    .reqBReady   (reqBReady),
    .reqRValid   (reqRValid),
    .reqRReady   (reqRReady),
    .capIsWrite  (capIsWrite),
    .hostAwValid (hostAwValid),
    .hostWValid  (hostWValid),
    .hostAwReady (hostAwReady),
    .hostWReady  (hostWReady),
    .hostBValid  (hostBValid),
    .hostBReady  (hostBReady),
    .hostArValid (hostArValid),
    .hostArReady (hostArReady),
    .hostRValid  (hostRValid),
    .hostRReady  (hostRReady),
    .hostWrIdx   (hostWrIdx),
    .hostCmdBit  (hostWStrb[0] & hostWData[0]),
    .pending     (pending),
    .strobe      (strobe)
  );

  trap_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pending    (pending),
    .awId       (reqAwId),
    .awAddr     (reqAwAddr),
    .awSize     (reqAwSize),
    .wData      (reqWData),
    .wStrb      (reqWStrb),
    .arId       (reqArId),
    .arAddr     (reqArAddr),
    .arSize     (reqArSize),
    .hostRdIdx  (hostRdIdx),
    .hostWData  (hostWData),
    .hostWStrb  (hostWStrb),
    .capIsWrite (capIsWrite),
    .rspId      (rspId),
    .rspData    (rspData),
    .rspCode    (rspCode),
    .hostRData  (hostRData)
  );

  assign reqBId    = rspId;
  assign reqRId    = rspId;
  assign reqBResp  = rspCode;
  assign reqRResp  = rspCode;
  assign reqRData  = rspData;
  assign reqRLast  = 1'b1;
  assign hostBResp = RESP_OKAY;
  assign hostRResp = RESP_OKAY;
  assign irq       = pending;

endmodule

// File: rtl/trap_chk.sv
module trap_chk #(
  parameter int unsigned ID_W   = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAwValid,
  input logic              reqAwReady,
  input logic              reqWReady,
  input logic              reqArValid,
  input logic              reqArReady,
  input logic              reqBValid,
  input logic              reqBReady,
  input logic [ID_W-1:0]   reqBId,
  input logic [1:0]        reqBResp,
  input logic              reqRValid,
  input logic              reqRReady,
  input logic [ID_W-1:0]   reqRId,
  input logic [DATA_W-1:0] reqRData,
  input logic [1:0]        reqRResp,
  input logic              reqRLast,
  input logic              hostBValid,
  input logic              hostBReady,
  input logic              hostRValid,
  input logic              hostRReady,
  input logic [DATA_W-1:0] hostRData,
  input logic              irq
);

  // R1
  aw_w_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAwReady |-> reqWReady);

  // R3
  irq_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past((reqAwValid && reqAwReady) || (reqArValid && reqArReady)));

  // R4
  busy_noaccept_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!reqAwReady && !reqWReady && !reqArReady));

  // R5
  no_early_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (!reqBValid && !reqRValid));

  // R6
  b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqBValid && !reqBReady) |=> (reqBValid && $stable(reqBId) && $stable(reqBResp)));

  // R6
  one_beat_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqBValid && reqRValid));

  // R7
  r_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqRValid && !reqRReady) |=> (reqRValid && $stable(reqRData) && $stable(reqRResp) && $stable(reqRId)));

  // R7
  rlast_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqRValid |-> reqRLast);

  // R8
  wr_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqArReady |-> !reqAwValid);

  // R10
  host_b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostBValid && !hostBReady) |=> hostBValid);

  // R10
  host_r_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRValid && !hostRReady) |=> (hostRValid && $stable(hostRData)));

endmodule

bind bus_trap_mailbox trap_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/bus_trap_mailbox_tb.sv
`timescale 1ns/1ps
module bus_trap_mailbox_tb;

  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned HOST_AW = 5;
  localparam int unsigned STRB_W  = DATA_W / 8;
  localparam realtime     CLK_P   = 4.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ID_W-1:0] reqAwId = '0, reqArId = '0, reqBId, reqRId;
  logic [ADDR_W-1:0] reqAwAddr = '0, reqArAddr = '0;
  logic [2:0] reqAwSize = '0, reqArSize = '0;
  logic reqAwValid = 0, reqWValid = 0, reqArValid = 0, reqBReady = 0, reqRReady = 0;
  logic reqAwReady, reqWReady, reqArReady, reqBValid, reqRValid, reqRLast;
  logic [DATA_W-1:0] reqWData = '0, reqRData;
  logic [STRB_W-1:0] reqWStrb = '0;
  logic [1:0] reqBResp, reqRResp;
  logic [HOST_AW-1:0] hostAwAddr = '0, hostArAddr = '0;
  logic hostAwValid = 0, hostWValid = 0, hostArValid = 0, hostBReady = 1, hostRReady = 1;
  logic hostAwReady, hostWReady, hostBValid, hostArReady, hostRValid, irq;
  logic [DATA_W-1:0] hostWData = '0, hostRData;
  logic [STRB_W-1:0] hostWStrb = '0;
  logic [1:0] hostBResp, hostRResp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  bus_trap_mailbox #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .HOST_AW(HOST_AW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqAwId(reqAwId), .reqAwAddr(reqAwAddr), .reqAwSize(reqAwSize), .reqAwValid(reqAwValid),
    .reqAwReady(reqAwReady), .reqWData(reqWData), .reqWStrb(reqWStrb), .reqWValid(reqWValid),
    .reqWReady(reqWReady), .reqBId(reqBId), .reqBResp(reqBResp), .reqBValid(reqBValid),
    .reqBReady(reqBReady), .reqArId(reqArId), .reqArAddr(reqArAddr), .reqArSize(reqArSize),
    .reqArValid(reqArValid), .reqArReady(reqArReady), .reqRId(reqRId), .reqRData(reqRData),
    .reqRResp(reqRResp), .reqRLast(reqRLast), .reqRValid(reqRValid), .reqRReady(reqRReady),
    .hostAwAddr(hostAwAddr), .hostAwValid(hostAwValid), .hostAwReady(hostAwReady),
    .hostWData(hostWData), .hostWStrb(hostWStrb), .hostWValid(hostWValid), .hostWReady(hostWReady),
    .hostBResp(hostBResp), .hostBValid(hostBValid), .hostBReady(hostBReady),
    .hostArAddr(hostArAddr), .hostArValid(hostArValid), .hostArReady(hostArReady),
    .hostRData(hostRData), .hostRResp(hostRResp), .hostRValid(hostRValid), .hostRReady(hostRReady),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R10: host write, OKAY response checked on the B beat
  task automatic hostWrite(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    hostAwAddr = a; hostWData = d; hostWStrb = s; hostAwValid = 1; hostWValid = 1;
    #1;
    while (!hostAwReady) begin @(negedge clk); #1; end
    @(negedge clk);
    hostAwValid = 0; hostWValid = 0;
    chk("R10 host bvalid/bresp", {29'd0, hostBValid, hostBResp}, 32'd4);
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hostArAddr = a; hostArValid = 1;
    #1;
    while (!hostArReady) begin @(negedge clk); #1; end
    @(negedge clk);
    hostArValid = 0;
    chk("R10 host rvalid/rresp", {29'd0, hostRValid, hostRResp}, 32'd4);
    d = hostRData;
  endtask

  task automatic reqWrite(input logic [3:0] id, input logic [31:0] a, input logic [2:0] sz,
                          input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    reqAwId = id; reqAwAddr = a; reqAwSize = sz; reqWData = d; reqWStrb = s;
    reqAwValid = 1; reqWValid = 1;
    #1;
    while (!reqAwReady) begin @(negedge clk); #1; end
    chk("R1 wready paired", {31'd0, reqWReady}, 32'd1);
    @(negedge clk);
    reqAwValid = 0; reqWValid = 0;
  endtask

  task automatic reqRead(input logic [3:0] id, input logic [31:0] a, input logic [2:0] sz);
    @(negedge clk);
    reqArId = id; reqArAddr = a; reqArSize = sz; reqArValid = 1;
    #1;
    while (!reqArReady) begin @(negedge clk); #1; end
    @(negedge clk);
    reqArValid = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] statusBefore;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 bvalid/rvalid", {30'd0, reqBValid, reqRValid}, 32'd0);
    chk("R11 readies", {29'd0, reqAwReady, reqWReady, reqArReady}, 32'd0);
    hostRead(5'h00, rd);
    chk("R11 status", rd, 32'd0);

    // sweep: both directions x all four response codes
    for (int k = 0; k < 8; k++) begin
      automatic logic        isWr = (k < 4);
      automatic logic [1:0]  code = 2'(k % 4);
      automatic logic [3:0]  id   = 4'(k + 3);
      automatic logic [31:0] addr = 32'h4000_0000 + 32'(k) * 32'h104;
      automatic logic [2:0]  sz   = 3'(k % 3);
      automatic logic [31:0] wd   = 32'hA500_0000 ^ (32'(k) * 32'h0101_0101);
      automatic logic [3:0]  st   = 4'(1 << (k % 4)) | 4'h1;
      automatic logic [31:0] rspD = 32'h1234_0000 + 32'(k) * 32'd7;
      if (isWr) reqWrite(id, addr, sz, wd, st);
      else      reqRead(id, addr, sz);
      chk("R3 irq after accept", {31'd0, irq}, 32'd1);
      hostRead(5'h00, rd);
      chk(isWr ? "R1 status" : "R2 status", rd, {30'd0, isWr, 1'b1});
      hostRead(5'h04, rd);
      chk(isWr ? "R1 addr" : "R2 addr", rd, addr);
      hostRead(5'h08, rd);
      chk(isWr ? "R1 wdata" : "R2 wdata zero", rd, isWr ? wd : 32'd0);
      hostRead(5'h0C, rd);
      chk(isWr ? "R1 size" : "R2 size", rd, {29'd0, sz});
      hostRead(5'h10, rd);
      chk(isWr ? "R1 strb" : "R2 strb zero", rd, isWr ? {28'd0, st} : 32'd0);
      // R4: new requests offered while pending must be refused
      @(negedge clk);
      reqAwValid = 1; reqWValid = 1; reqArValid = 1;
      #1;
      chk("R4 readies low", {29'd0, reqAwReady, reqWReady, reqArReady}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R5 no early response", {30'd0, reqBValid, reqRValid}, 32'd0);
      reqAwValid = 0; reqWValid = 0; reqArValid = 0;
      hostWrite(5'h18, {30'd0, code}, 4'hF);
      hostWrite(5'h14, rspD, 4'hF);
      hostRead(5'h14, rd);
      chk("R10 rsp data readback", rd, rspD);
      hostRead(5'h18, rd);
      chk("R10 rsp code readback", rd, {30'd0, code});
      chk("R3 irq held", {31'd0, irq}, 32'd1);
      chk("R5 still no response", {30'd0, reqBValid, reqRValid}, 32'd0);
      hostWrite(5'h1C, 32'd1, 4'h1);
      chk("R3 irq cleared", {31'd0, irq}, 32'd0);
      if (isWr) begin
        chk("R6 bvalid", {30'd0, reqBValid, reqRValid}, 32'd2);
        chk("R6 bid", {28'd0, reqBId}, {28'd0, id});
        chk("R6 bresp", {30'd0, reqBResp}, {30'd0, code});
      end else begin
        chk("R7 rvalid", {30'd0, reqBValid, reqRValid}, 32'd1);
        chk("R7 rid", {28'd0, reqRId}, {28'd0, id});
        chk("R7 rdata", reqRData, rspD);
        chk("R7 rresp/rlast", {29'd0, reqRResp, reqRLast}, {29'd0, code, 1'b1});
      end
      @(negedge clk);
      #1;
      chk("R4 readies low in response", {29'd0, reqAwReady, reqWReady, reqArReady}, 32'd0);
      chk(isWr ? "R6 held" : "R7 held", {30'd0, reqBValid, reqRValid}, isWr ? 32'd2 : 32'd1);
      reqBReady = isWr; reqRReady = !isWr;
      @(negedge clk);
      reqBReady = 0; reqRReady = 0;
      chk(isWr ? "R6 beat done" : "R7 beat done", {30'd0, reqBValid, reqRValid}, 32'd0);
      hostRead(5'h00, rd);
      chk("R3 status after", rd, {30'd0, isWr, 1'b0});
    end

    // R9: stray completion command while idle
    hostRead(5'h00, statusBefore);
    hostWrite(5'h1C, 32'd1, 4'h1);
    repeat (2) @(negedge clk);
    chk("R9 no beat", {30'd0, reqBValid, reqRValid}, 32'd0);
    chk("R9 irq low", {31'd0, irq}, 32'd0);
    hostRead(5'h00, rd);
    chk("R9 status unchanged", rd, statusBefore);

    // R8: write and read offered together
    @(negedge clk);
    reqAwId = 4'd9;  reqAwAddr = 32'h0000_1000; reqAwSize = 3'd2;
    reqWData = 32'hCAFE_0001; reqWStrb = 4'hF;
    reqArId = 4'd10; reqArAddr = 32'h0000_2000; reqArSize = 3'd1;
    reqAwValid = 1; reqWValid = 1; reqArValid = 1;
    #1;
    chk("R8 write taken first", {30'd0, reqAwReady, reqArReady}, 32'd2);
    @(negedge clk);
    reqAwValid = 0; reqWValid = 0;
    #1;
    chk("R8 read waits", {31'd0, reqArReady}, 32'd0);
    hostRead(5'h00, rd);
    chk("R8 status write", rd, 32'd3);
    hostRead(5'h04, rd);
    chk("R8 write addr", rd, 32'h0000_1000);
    hostWrite(5'h18, 32'd0, 4'hF);
    hostWrite(5'h1C, 32'd1, 4'h1);
    #1;
    chk("R8 read waits for B", {31'd0, reqArReady}, 32'd0);
    chk("R8 bid", {28'd0, reqBId}, 32'd9);
    reqBReady = 1;
    @(negedge clk);
    reqBReady = 0;
    #1;
    chk("R8 read taken after B", {31'd0, reqArReady}, 32'd1);
    @(negedge clk);
    reqArValid = 0;
    hostRead(5'h00, rd);
    chk("R8 status read", rd, 32'd1);
    hostRead(5'h04, rd);
    chk("R8 read addr", rd, 32'h0000_2000);

    // R10: byte strobes on response data, read-only registers ignore writes
    hostWrite(5'h14, 32'hFFFF_FFFF, 4'hF);
    hostWrite(5'h14, 32'h0000_0000, 4'b0101);
    hostRead(5'h14, rd);
    chk("R10 strobed rsp data", rd, 32'hFF00_FF00);
    hostWrite(5'h04, 32'hDEAD_BEEF, 4'hF);
    hostRead(5'h04, rd);
    chk("R10 addr read-only", rd, 32'h0000_2000);
    hostWrite(5'h00, 32'h0, 4'hF);
    hostRead(5'h00, rd);
    chk("R10 status read-only", rd, 32'd1);
    hostWrite(5'h18, 32'd3, 4'hF);
    hostWrite(5'h1C, 32'd1, 4'h1);
    chk("R7 rdata strobed", reqRData, 32'hFF00_FF00);
    chk("R7 rid/rresp", {26'd0, reqRId, reqRResp}, {26'd0, 4'd10, 2'd3});
    reqRReady = 1;
    @(negedge clk);
    reqRReady = 0;
    chk("R7 final beat done", {31'd0, reqRValid}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule